// File: doc/BRIEF.md
# Polarity-Aware GPIO Register Bank

This block holds the register state of an 8-bit bidirectional general-purpose port and sits behind a serial-bus bridge. The bridge presents a register pointer, a byte of write data, and single-cycle write and read strobes. The block keeps three writable registers and one read-only input view:

- an output-level register;
- a direction register, where a set bit makes the pin an input and a clear bit turns its driver on;
- a per-bit inversion mask that applies to input reads.

The block drives an output-enable bus and an output-data bus toward the pads. It also samples the pad input levels through a short synchronizer.

A read is registered. On the cycle that the read strobe is high, the selected value is captured into the read-data register. The captured value then stays unchanged until the next read strobe, so the bridge can shift out a byte while the pins keep moving. For the input register, this capture is the input latch: the synchronized pin levels, XORed with the inversion mask, are taken at the start of the read byte.

Top module: `gpio_polar_bank`

## Requirements
- R1: After reset the output register reads 0xFF, the inversion mask reads 0x00 and the direction register reads 0xFF. Before any strobe, `oeOut` is 0x00, `pinOut` is 0x00 and `rdData` is 0x00.
- R2: Pointer 1 selects the output register, pointer 2 the inversion mask and pointer 3 the direction register. A write strobe stores `wrData` into the selected register. A read strobe makes `rdData` equal to that register's value one clock later.
- R3: A write strobe with pointer 0 changes no register, no pin output and no output enable.
- R4: `oeOut[i]` is 1 exactly when direction bit i is 0. Direction bit i set to 1 makes pin i an input with its driver off.
- R5: `pinOut[i]` equals output-register bit i while pin i is an output, and is 0 while pin i is an input, whatever the output register holds.
- R6: A read strobe with pointer 0 makes `rdData` equal to the pin levels XOR the inversion mask one clock later. A mask bit of 1 inverts that pin; a mask bit of 0 passes it unchanged. The pin levels used are those of `pinIn` SYNC_STAGES clock edges before the strobe edge (2 by default).
- R7: Input reads reflect `pinIn` whether each pin is configured as an input or as an output.
- R8: A read of pointer 1 returns the stored output-register value, not the level on `pinIn`.
- R9: `rdData` changes only on the clock edge that samples a read strobe. Between strobes it holds its value even when `pinIn` changes.
- R10: For a pointer value above 3, a read returns 0x00 and a write changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regPtr | input | PTR_W (8) | Register pointer from the serial bridge |
| wrData | input | WIDTH (8) | Byte to be written |
| wrStb | input | 1 | Single-cycle write strobe |
| rdStb | input | 1 | Single-cycle read strobe; loads `rdData` |
| rdData | output | WIDTH (8) | Registered read byte |
| pinIn | input | WIDTH (8) | Pad input levels (asynchronous) |
| pinOut | output | WIDTH (8) | Output data toward the pads |
| oeOut | output | WIDTH (8) | Per-pin output-driver enable |

## Verification
The inversion mask is swept through all 256 values against a changing pin pattern. This separates a per-bit XOR from a full inversion, from a missing inversion and from swapped bits.

The pin pattern is swept through all 256 values under a fixed mask, first with every pin an input and then with every pin an output. This shows that input reads follow the pins and ignore the direction setting.

The direction register is swept through all 256 values with a fixed output pattern. This confirms that the enables and the gated output data follow each bit independently.

Separate cases cover the remaining behaviour:
- reads of the output register with conflicting pin levels;
- writes to pointer 0 and to out-of-range pointers;
- reads of out-of-range pointers;
- holding of `rdData` between strobes while the pins toggle.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  typedef enum logic [1:0] {
    SEL_IN  = 2'd0,
    SEL_OUT = 2'd1,
    SEL_POL = 2'd2,
    SEL_CFG = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrOut;
    logic    wrPol;
    logic    wrCfg;
    logic    rdLoad;
    logic    rdValid;
    regSel_e sel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpb_ctrl.sv
module gpb_ctrl
  import gpb_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic [PTR_W-1:0] regPtr,
  input  logic             wrStb,
  input  logic             rdStb,
  output ctrlStrobes_t     strb
);

  localparam int NUM_REGS = 4;
  localparam logic [PTR_W-1:0] PTR_LIMIT = PTR_W'(NUM_REGS);

  logic    inRange;
  regSel_e selDec;

  always_comb begin
    inRange = (regPtr < PTR_LIMIT);
    selDec  = regSel_e'(regPtr[1:0]);
  end

  always_comb begin
    strb.sel     = selDec;
    strb.rdValid = inRange;
    strb.rdLoad  = rdStb;
    // Pointer 0 and out-of-range pointers produce no write strobe (R3, R10)
    strb.wrOut   = wrStb && inRange && (selDec == SEL_OUT);
    strb.wrPol   = wrStb && inRange && (selDec == SEL_POL);
    strb.wrCfg   = wrStb && inRange && (selDec == SEL_CFG);
  end

endmodule

// File: rtl/gpb_datapath.sv
module gpb_datapath
  import gpb_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] OUT_RST     = '1,
  parameter logic [WIDTH-1:0] POL_RST     = '0,
  parameter logic [WIDTH-1:0] CFG_RST     = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] oeOut
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] syncPins;
  logic [WIDTH-1:0] outReg;
  logic [WIDTH-1:0] polReg;
  logic [WIDTH-1:0] cfgReg;
  logic [WIDTH-1:0] rdMux;

  // Pin synchronizer
  genvar gs;
  generate
    for (gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
      if (gs == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gs] <= '0;
          else       syncQ[gs] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gs] <= '0;
          else       syncQ[gs] <= syncQ[gs-1];
        end
      end
    end
  endgenerate

  assign syncPins = syncQ[LAST_STAGE];

  // Control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= OUT_RST;
      polReg <= POL_RST;
      cfgReg <= CFG_RST;
    end else begin
      if (strb.wrOut) outReg <= wrData;
      if (strb.wrPol) polReg <= wrData;
      if (strb.wrCfg) cfgReg <= wrData;
    end
  end

  // Read selection; input view is pins XOR mask, independent of direction
  always_comb begin
    unique case (strb.sel)
      SEL_IN:  rdMux = syncPins ^ polReg;
      SEL_OUT: rdMux = outReg;
      SEL_POL: rdMux = polReg;
      SEL_CFG: rdMux = cfgReg;
      default: rdMux = '0;
    endcase
  end

  // Read latch: captured once per read byte, held in between
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdLoad) begin
      rdData <= strb.rdValid ? rdMux : '0;
    end
  end

  // Pad side: direction bit 1 = input (driver off)
  genvar gp;
  generate
    for (gp = 0; gp < WIDTH; gp++) begin : g_pin
      always_comb begin
        oeOut[gp]  = ~cfgReg[gp];
        pinOut[gp] = cfgReg[gp] ? 1'b0 : outReg[gp];
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_polar_bank.sv
module gpio_polar_bank
  import gpb_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int PTR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PTR_W-1:0] regPtr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrStb,
  input  logic             rdStb,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] oeOut
);

  ctrlStrobes_t strb;

  gpb_ctrl #(
    .PTR_W(PTR_W)
  ) i_ctrl (
    .regPtr(regPtr),
    .wrStb (wrStb),
    .rdStb (rdStb),
    .strb  (strb)
  );

  gpb_datapath #(
    .WIDTH      (WIDTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(wrData),
    .pinIn (pinIn),
    .rdData(rdData),
    .pinOut(pinOut),
    .oeOut (oeOut)
  );

endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
  parameter int WIDTH = 8,
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [PTR_W-1:0] regPtr,
  input logic [WIDTH-1:0] wrData,
  input logic             wrStb,
  input logic             rdStb,
  input logic [WIDTH-1:0] rdData,
  input logic [WIDTH-1:0] pinOut,
  input logic [WIDTH-1:0] oeOut
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(3);

  a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && regPtr == PTR_W'(3)) |=> (oeOut == ~$past(wrData)));

  a_r5_out_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && regPtr == PTR_W'(1) && !rdStb) |=> (pinOut == ($past(wrData) & oeOut)));

  a_r3_input_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && regPtr == '0) |=> ($stable(pinOut) && $stable(oeOut)));

  a_r10_bad_ptr_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && regPtr > PTR_LAST) |=> ($stable(pinOut) && $stable(oeOut)));

  a_r10_bad_ptr_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && regPtr > PTR_LAST) |=> (rdData == '0));

  a_r9_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(rdData));

endmodule

bind gpio_polar_bank gpb_checker #(
  .WIDTH(WIDTH),
  .PTR_W(PTR_W)
) i_gpb_checker (
  .clk   (clk),
  .rstN  (rstN),
  .regPtr(regPtr),
  .wrData(wrData),
  .wrStb (wrStb),
  .rdStb (rdStb),
  .rdData(rdData),
  .pinOut(pinOut),
  .oeOut (oeOut)
);

// File: tb/test_gpio_polar_bank.sv
module test_gpio_polar_bank;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regPtr = '0;
  logic [7:0] wrData = '0;
  logic       wrStb = 1'b0;
  logic       rdStb = 1'b0;
  logic [7:0] rdData;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] oeOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_polar_bank #(.WIDTH(8), .PTR_W(8), .SYNC_STAGES(SYNC)) i_gpio_polar_bank (
    .clk(clk), .rstN(rstN), .regPtr(regPtr), .wrData(wrData), .wrStb(wrStb),
    .rdStb(rdStb), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .oeOut(oeOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] p, input logic [7:0] d);
    regPtr = p; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic rd(input logic [7:0] p, output logic [7:0] v);
    regPtr = p; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    v = rdData;
  endtask

  task automatic setPins(input logic [7:0] v);
    pinIn = v;
    repeat (SYNC) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] held;
    logic [7:0] pinPat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", oeOut, 8'h00);
    chk("R1 pinOut", pinOut, 8'h00);
    chk("R1 rdData", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 oe after release", oeOut, 8'h00);
    rd(8'd1, v); chk("R1 out default", v, 8'hFF);
    rd(8'd2, v); chk("R1 pol default", v, 8'h00);
    rd(8'd3, v); chk("R1 cfg default", v, 8'hFF);

    // R2 write/readback
    wr(8'd1, 8'h96); rd(8'd1, v); chk("R2 out readback", v, 8'h96);
    wr(8'd2, 8'h3C); rd(8'd2, v); chk("R2 pol readback", v, 8'h3C);
    wr(8'd3, 8'hC3); rd(8'd3, v); chk("R2 cfg readback", v, 8'hC3);

    // R4/R5 sweep of direction register with fixed output pattern
    wr(8'd1, 8'h3C);
    for (int c = 0; c < 256; c++) begin
      wr(8'd3, 8'(c));
      chk("R4 oe", oeOut, ~8'(c));
      chk("R5 pinOut", pinOut, 8'h3C & ~8'(c));
    end

    // R6 inversion mask sweep
    wr(8'd3, 8'hFF);
    for (int m = 0; m < 256; m++) begin
      pinPat = 8'((m * 37 + 11) & 8'hFF);
      wr(8'd2, 8'(m));
      setPins(pinPat);
      rd(8'd0, v);
      chk("R6 input xor mask", v, pinPat ^ 8'(m));
    end

    // R7 pin sweep with all inputs, then all outputs
    wr(8'd2, 8'h5A);
    for (int p = 0; p < 256; p++) begin
      setPins(8'(p));
      rd(8'd0, v);
      chk("R7 input pins (cfg=inputs)", v, 8'(p) ^ 8'h5A);
    end
    wr(8'd3, 8'h00);
    wr(8'd1, 8'h0F);
    for (int p = 0; p < 256; p++) begin
      setPins(8'(p));
      rd(8'd0, v);
      chk("R7 input pins (cfg=outputs)", v, 8'(p) ^ 8'h5A);
    end

    // R8 output read returns stored value, not pins
    wr(8'd1, 8'hA5);
    setPins(8'h00);
    rd(8'd1, v); chk("R8 out vs pins low", v, 8'hA5);
    setPins(8'hFF);
    rd(8'd1, v); chk("R8 out vs pins high", v, 8'hA5);
    chk("R5 pinOut as outputs", pinOut, 8'hA5);

    // R3 write to pointer 0 ignored
    wr(8'd0, 8'h00);
    chk("R3 pinOut unchanged", pinOut, 8'hA5);
    chk("R3 oe unchanged", oeOut, 8'hFF);
    rd(8'd0, v); chk("R3 input read unchanged", v, 8'hFF ^ 8'h5A);
    rd(8'd2, v); chk("R3 pol unchanged", v, 8'h5A);

    // R9 read data held between strobes
    setPins(8'h81);
    rd(8'd0, held);
    chk("R9 captured", held, 8'h81 ^ 8'h5A);
    for (int k = 0; k < 8; k++) begin
      pinIn = 8'(k * 29 + 3);
      repeat (3) @(negedge clk);
      chk("R9 rdData held", rdData, 8'h81 ^ 8'h5A);
    end

    // R10 out-of-range pointers
    wr(8'd4, 8'h00);
    wr(8'd7, 8'h11);
    wr(8'hFF, 8'h22);
    rd(8'd1, v); chk("R10 out unchanged", v, 8'hA5);
    rd(8'd2, v); chk("R10 pol unchanged", v, 8'h5A);
    rd(8'd3, v); chk("R10 cfg unchanged", v, 8'h00);
    rd(8'd4, v); chk("R10 read ptr 4", v, 8'h00);
    rd(8'hFF, v); chk("R10 read ptr 255", v, 8'h00);
    for (int q = 4; q < 256; q += 23) begin
      rd(8'd1, v);
      rd(8'(q), v);
      chk("R10 read high ptr", v, 8'h00);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule